// File: doc/BRIEF.md
# Masked-Write Register Endpoint with Four-Phase Handshake

This block is one hardware-owned register that answers the external access requests of a register file. It has two channels, one for writes and one for reads. Each channel uses a fully interlocked four-phase request/acknowledge exchange.

On a write, the block builds a bit mask from the byte enables. It then changes only the register bits under that mask. If the mask touches a configured read-only bit range, the block rejects the whole write and raises an error for the length of the acknowledge. On a read, it returns the whole register and ignores the byte enables.

The block serves one request at a time. When both requests arrive together, it serves the write first. A fixed latency parameter delays every acknowledge, so the requester sees real stalls.

Top module: `ext_reg_endpoint`

## Requirements
- R1: After reset, `wr_ack`, `wr_err`, `rd_ack` and `rd_err` are low, and a read returns `RESET_VAL`.
- R2: A write changes register bit b only when `wr_be[b/8]` is 1. The mask is each byte enable copied over the eight bits of its byte, so bits 8i..8i+7 follow `wr_be[i]`. All other bits keep their value. A write with all enables at 0 changes nothing.
- R3: A write takes effect exactly once, in the first cycle its request is seen while the block is idle. Later changes of `wr_data` while the request is held have no effect.
- R4: An acknowledge rises `ACK_LAT`+1 cycles after the first cycle in which the block, while idle, sees its request high. The acknowledge stays high while the request stays high, and falls the cycle after the request is seen low.
- R5: A write whose mask sets any bit in `RO_LO`..`RO_HI` changes no bit. `wr_err` is high on every cycle its `wr_ack` is high. A legal write never raises `wr_err`.
- R6: A read returns the full register on `rd_data` while `rd_ack` is high, and `rd_err` never rises.
- R7: `rd_data` does not change while `rd_ack` is high, even when a write request is pending at the same time.
- R8: When both requests are first seen in the same cycle, the write gets its complete handshake first. `rd_ack` stays low until then, and the read afterwards returns the value after the write.
- R9: `wr_ack` and `rd_ack` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Write request, held until acknowledged |
| wr_data | input | DATA_W | Write data |
| wr_be | input | DATA_W/8 | Byte enables, one per data byte |
| wr_ack | output | 1 | Write acknowledge |
| wr_err | output | 1 | Write error, valid with wr_ack |
| rd_req | input | 1 | Read request, held until acknowledged |
| rd_data | output | DATA_W | Register contents |
| rd_ack | output | 1 | Read acknowledge |
| rd_err | output | 1 | Read error, always low |

## Verification
The bench builds the block with `DATA_W`=32, `ACK_LAT`=3, a read-only range of bits 24..27 and a reset value whose read-only nibble is non-zero. The latency of 3 opens a multi-cycle stall window. In that window the bench changes the write data after acceptance, and it queues a write behind a held read acknowledge. The read-only nibble sits inside the top byte, so a top-byte write is rejected even though half of that byte is writable. This tests that the whole write is dropped rather than only the protected bits.

// File: rtl/ext_ep_pkg.sv
package ext_ep_pkg;
    typedef enum logic [1:0] {
        EP_IDLE = 2'd0,
        EP_WAIT = 2'd1,
        EP_ACK  = 2'd2
    } ep_state_e;
endpackage

// File: rtl/ep_mask_gen.sv
module ep_mask_gen #(
    parameter int DATA_W = 32,
    localparam int BE_W = DATA_W / 8
) (
    input  logic [BE_W-1:0]   be,
    output logic [DATA_W-1:0] mask
);
    for (genvar i = 0; i < BE_W; i++) begin : g_byte
        assign mask[i*8 +: 8] = {8{be[i]}};
    end

    // R2: every enable contributes exactly eight mask bits
    always_comb begin
        p_mask_width_r2: assert ($countones(mask) == 8 * $countones(be))
            else $error("mask width mismatch");
    end
endmodule

// File: rtl/ep_ro_check.sv
module ep_ro_check #(
    parameter int DATA_W = 32,
    parameter bit RO_EN  = 1'b1,
    parameter int RO_LO  = 24,
    parameter int RO_HI  = 27
) (
    input  logic [DATA_W-1:0] mask,
    output logic              hit
);
    logic [DATA_W-1:0] ro_bits;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign ro_bits[b] = RO_EN && (b >= RO_LO) && (b <= RO_HI);
    end

    assign hit = |(mask & ro_bits);
endmodule

// File: rtl/ext_reg_endpoint.sv
module ext_reg_endpoint
    import ext_ep_pkg::*;
#(
    parameter int               DATA_W    = 32,
    parameter int               ACK_LAT   = 2,
    parameter bit               RO_EN     = 1'b1,
    parameter int               RO_LO     = 24,
    parameter int               RO_HI     = 27,
    parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_req,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [DATA_W/8-1:0]   wr_be,
    output logic                  wr_ack,
    output logic                  wr_err,
    input  logic                  rd_req,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  rd_ack,
    output logic                  rd_err
);
    localparam int BE_W  = DATA_W / 8;
    localparam int CNT_W = 3;
    localparam logic [CNT_W-1:0] LAT_C = CNT_W'(ACK_LAT);

    typedef struct packed {
        ep_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic              serve_wr;
        logic              err;
        logic [DATA_W-1:0] regv;
    } ep_st_t;

    localparam ep_st_t ST_RESET = '{
        state:    EP_IDLE,
        cnt:      '0,
        serve_wr: 1'b0,
        err:      1'b0,
        regv:     RESET_VAL
    };

    ep_st_t st_d, st_q;
    logic [DATA_W-1:0] wmask;
    logic              ro_hit;
    logic              idle_q;

    ep_mask_gen #(.DATA_W(DATA_W)) u_mask (
        .be   (wr_be),
        .mask (wmask)
    );

    ep_ro_check #(
        .DATA_W (DATA_W),
        .RO_EN  (RO_EN),
        .RO_LO  (RO_LO),
        .RO_HI  (RO_HI)
    ) u_ro (
        .mask (wmask),
        .hit  (ro_hit)
    );

    assign idle_q = (st_q.state == EP_IDLE);

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            EP_IDLE: begin
                if (wr_req || rd_req) begin
                    st_d.serve_wr = wr_req;
                    st_d.err      = wr_req && ro_hit;
                    if (wr_req && !ro_hit) begin
                        st_d.regv = (st_q.regv & ~wmask) | (wr_data & wmask);
                    end
                    if (ACK_LAT == 0) begin
                        st_d.state = EP_ACK;
                    end else begin
                        st_d.state = EP_WAIT;
                        st_d.cnt   = LAT_C;
                    end
                end
            end
            EP_WAIT: begin
                if (st_q.cnt <= CNT_W'(1)) begin
                    st_d.state = EP_ACK;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            EP_ACK: begin
                if (st_q.serve_wr ? !wr_req : !rd_req) begin
                    st_d.state = EP_IDLE;
                    st_d.err   = 1'b0;
                end
            end
            default: st_d = ST_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ack  = (st_q.state == EP_ACK) && st_q.serve_wr;
    assign rd_ack  = (st_q.state == EP_ACK) && !st_q.serve_wr;
    assign wr_err  = wr_ack && st_q.err;
    assign rd_err  = 1'b0;
    assign rd_data = st_q.regv;

    // R4: acknowledge held while request held, released after request drops
    p_wr_ack_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack && wr_req |=> wr_ack);
    p_wr_ack_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack && !wr_req |=> !wr_ack);
    p_rd_ack_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack && rd_req |=> rd_ack);
    // R5: error lasts as long as the acknowledge
    p_err_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack && wr_err && wr_req |=> wr_err);
    // R5: rejected write leaves the register alone
    p_ro_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        idle_q && wr_req && ro_hit |=> $stable(st_q.regv));
    // R3: register only moves on write acceptance
    p_reg_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(idle_q && wr_req) |=> $stable(st_q.regv));
    // R7: read data stable across a held read acknowledge
    p_rd_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack && rd_req |=> $stable(rd_data));
    // R8: simultaneous requests serve the write first
    p_wr_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        idle_q && wr_req && rd_req |=> !rd_ack);
    // R9: acknowledges exclusive
    p_one_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_ack, rd_ack}));
endmodule

// File: tb/sim_ext_reg_endpoint.sv
module sim_ext_reg_endpoint;
    localparam int DW  = 32;
    localparam int LAT = 3;
    localparam int ROL = 24;
    localparam int ROH = 27;
    localparam logic [DW-1:0] RV = 32'h0B00_1234;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_req = 1'b0, rd_req = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [3:0] wr_be = '0;
    logic wr_ack, wr_err, rd_ack, rd_err;
    logic [DW-1:0] rd_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // reference model state
    int m_mode = 0;      // 0 idle, 1 waiting, 2 acknowledging
    int m_cnt = 0;
    bit m_wr = 1'b0;
    bit m_err = 1'b0;
    logic [DW-1:0] m_reg = RV;

    always #2 clk = ~clk;

    ext_reg_endpoint #(
        .DATA_W(DW), .ACK_LAT(LAT), .RO_EN(1'b1),
        .RO_LO(ROL), .RO_HI(ROH), .RESET_VAL(RV)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_req(wr_req), .wr_data(wr_data), .wr_be(wr_be),
        .wr_ack(wr_ack), .wr_err(wr_err),
        .rd_req(rd_req), .rd_data(rd_data),
        .rd_ack(rd_ack), .rd_err(rd_err)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step();
        logic [DW-1:0] mk;
        bit ro;
        for (int i = 0; i < 4; i++) mk[i*8 +: 8] = {8{wr_be[i]}};
        ro = 1'b0;
        for (int b = ROL; b <= ROH; b++) if (mk[b]) ro = 1'b1;
        if (m_mode == 0) begin
            if (wr_req || rd_req) begin
                m_wr  = wr_req;
                m_err = wr_req && ro;
                if (wr_req && !ro) m_reg = (m_reg & ~mk) | (wr_data & mk);
                m_mode = (LAT == 0) ? 2 : 1;
                m_cnt  = LAT;
            end
        end else if (m_mode == 1) begin
            m_cnt--;
            if (m_cnt == 0) m_mode = 2;
        end else begin
            if (m_wr ? !wr_req : !rd_req) begin
                m_mode = 0;
                m_err  = 1'b0;
            end
        end
    endtask

    task automatic compare();
        bit ewa, era;
        ewa = (m_mode == 2) && m_wr;
        era = (m_mode == 2) && !m_wr;
        chk(wr_ack == ewa, "R4 wr_ack", 64'(wr_ack), 64'(ewa));
        chk(rd_ack == era, "R4 rd_ack", 64'(rd_ack), 64'(era));
        chk(wr_err == (ewa && m_err), "R5 wr_err", 64'(wr_err), 64'(ewa && m_err));
        chk(rd_err == 1'b0, "R6 rd_err", 64'(rd_err), 64'd0);
        chk(!(wr_ack && rd_ack), "R9 exclusive acks", {wr_ack, rd_ack}, 64'd0);
        if (era) chk(rd_data == m_reg, "R6 rd_data", 64'(rd_data), 64'(m_reg));
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic do_write(input logic [DW-1:0] d, input logic [3:0] be, input bit exp_err);
        int n;
        wr_data = d; wr_be = be; wr_req = 1'b1;
        n = 0;
        do begin tick(); n++; end while (!wr_ack && n < 20);
        chk(n == LAT + 1, "R4 write ack latency", 64'(n), 64'(LAT + 1));
        chk(wr_err == exp_err, "R5 write error flag", 64'(wr_err), 64'(exp_err));
        wr_data = ~d;              // R3: late data change must be ignored
        tick(); tick();
        chk(wr_ack && (wr_err == exp_err), "R5 error held with ack",
            {wr_ack, wr_err}, {1'b1, exp_err});
        wr_req = 1'b0;
        tick();
        chk(!wr_ack && !wr_err, "R4 write ack release", {wr_ack, wr_err}, 64'd0);
    endtask

    task automatic do_read(output logic [DW-1:0] q);
        int n;
        rd_req = 1'b1;
        n = 0;
        do begin tick(); n++; end while (!rd_ack && n < 20);
        chk(n == LAT + 1, "R4 read ack latency", 64'(n), 64'(LAT + 1));
        q = rd_data;
        rd_req = 1'b0;
        tick();
        chk(!rd_ack, "R4 read ack release", 64'(rd_ack), 64'd0);
    endtask

    initial begin
        logic [DW-1:0] q;
        int n;
        repeat (3) @(negedge clk);
        chk(!wr_ack && !rd_ack && !wr_err && !rd_err, "R1 outputs in reset",
            {wr_ack, rd_ack, wr_err, rd_err}, 64'd0);
        rst_n = 1'b1;
        tick();
        do_read(q);
        chk(q == RV, "R1 reset value", 64'(q), 64'(RV));

        do_write(32'hDEAD_BEEF, 4'b0111, 1'b0);
        do_read(q);
        chk(q == 32'h0BAD_BEEF, "R2/R3 three-byte write", 64'(q), 64'h0BAD_BEEF);

        do_write(32'h1122_3344, 4'b0010, 1'b0);
        do_read(q);
        chk(q == 32'h0BAD_33EF, "R2 single-byte write", 64'(q), 64'h0BAD_33EF);

        do_write(32'hFFFF_FFFF, 4'b1000, 1'b1);
        do_read(q);
        chk(q == 32'h0BAD_33EF, "R5 read-only write dropped", 64'(q), 64'h0BAD_33EF);

        do_write(32'h0000_0000, 4'b1100, 1'b1);
        do_read(q);
        chk(q == 32'h0BAD_33EF, "R5 partial read-only write dropped", 64'(q), 64'h0BAD_33EF);

        do_write(32'h0000_0000, 4'b0000, 1'b0);
        do_read(q);
        chk(q == 32'h0BAD_33EF, "R2 empty mask no change", 64'(q), 64'h0BAD_33EF);

        // R8: both requests in the same cycle
        wr_data = 32'h0000_0055; wr_be = 4'b0001;
        wr_req = 1'b1; rd_req = 1'b1;
        n = 0;
        do begin
            tick(); n++;
            chk(!rd_ack, "R8 read held off during write", 64'(rd_ack), 64'd0);
        end while (!wr_ack && n < 20);
        wr_req = 1'b0;
        tick();
        n = 0;
        while (!rd_ack && n < 20) begin tick(); n++; end
        chk(rd_data == 32'h0BAD_3355, "R8 read after write", 64'(rd_data), 64'h0BAD_3355);
        rd_req = 1'b0;
        tick();

        // R7: write pending while read acknowledge is held
        rd_req = 1'b1;
        n = 0;
        do begin tick(); n++; end while (!rd_ack && n < 20);
        wr_data = 32'h0077_0000; wr_be = 4'b0100; wr_req = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk(rd_ack && rd_data == 32'h0BAD_3355, "R7 read data stable",
                64'(rd_data), 64'h0BAD_3355);
        end
        rd_req = 1'b0;
        n = 0;
        do begin tick(); n++; end while (!wr_ack && n < 20);
        chk(wr_ack && !wr_err, "R8 queued write served", {wr_ack, wr_err}, 64'd2);
        wr_req = 1'b0;
        tick();
        do_read(q);
        chk(q == 32'h0B77_3355, "R2 queued write result", 64'(q), 64'h0B77_3355);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule